// File: doc/BRIEF.md
# PCIe Root Port Bring-Up Sequencer

This block puts a PCIe root port through power-up in a fixed order and reports how it ended. A `start_i` pulse first puts the port into a held state: PHY test power-down asserted, link training enabled, reference clock gated, and the endpoint reset line pulled low. The endpoint reset is held low for a programmable time and then released. After that the block clears the training enable and presents the static PHY settings (root-port device type and the loss-of-signal threshold). It raises the optional board power switch, releases test power-down, and enables the reference clock.

Next the four functional clock gates are opened one after another. Each gate must return a ready acknowledge before the next one opens. If an acknowledge does not arrive in time, the gates that are open are closed again, highest first, and the block reports a clock error. Once all clocks are running, the block waits a settle time, sets the training enable again, and samples the link-up indication at a fixed interval. It stops with link-ok on the first poll that sees the link up. It stops with link-fail after a set number of polls that all fail.

Every delay is a parameter counted in clock cycles. The defaults assume a 125 MHz clock, and a bench can shrink the delays.

Top module: `pcie_bringup_seq`

## Requirements
- R1: After reset, `test_pd_o`=1 and `train_en_o`, `refclk_en_o`, `ep_rst_n_o`, `pwr_on_o`, `clk_en_o`, `link_ok_o`, `link_fail_o`, `clk_err_o`, `dev_type_o` and `los_level_o` are all 0.
- R2: An accepted `start_i` sets `train_en_o`=1, `test_pd_o`=1, `refclk_en_o`=0 and `ep_rst_n_o`=0 one edge later. `ep_rst_n_o` stays low for exactly RST_CYC cycles and then goes high in a step of its own.
- R3: One cycle after the endpoint reset is released, `train_en_o` drops to 0. In the same step `dev_type_o` becomes 4 (root port) and `los_level_o` becomes LOS_LEVEL (default 9). Both values remain until the next start.
- R4: `pwr_on_o` goes high one cycle after the PHY settings step, and only if `has_pwr_i` was 1 when start was accepted. One cycle later `test_pd_o` drops and `refclk_en_o` rises.
- R5: The bits of `clk_en_o` rise one at a time from bit 0 to bit N_CLK-1. Each bit rises in the cycle after the acknowledge of the previous bit is seen.
- R6: `train_en_o` is set again no sooner than SETTLE_CYC cycles (and no later than SETTLE_CYC+2) after the last clock enable rises.
- R7: `link_up_i` is sampled every POLL_GAP cycles. The first sample that is high sets `link_ok_o`.
- R8: If MAX_POLL samples in a row are low, `link_fail_o` rises exactly MAX_POLL*POLL_GAP cycles after `train_en_o` rose.
- R9: If an enabled clock gets no acknowledge within ACK_TMO cycles, that enable and every lower one are cleared, one per cycle, highest first. `clk_err_o` is then set, and `train_en_o` stays 0.
- R10: `start_i` in the idle, link-ok, link-fail or clock-error state restarts the sequence. In the same step as the R2 entry levels, it clears all status outputs and all clock enables.
- R11: `start_i` while a sequence is running has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin (or restart) the bring-up sequence |
| has_pwr_i | input | 1 | Board has a power switch to drive |
| clk_ack_i | input | N_CLK | Ready acknowledge per clock gate |
| link_up_i | input | 1 | Link-up indication from training logic |
| test_pd_o | output | 1 | PHY test power-down |
| train_en_o | output | 1 | Link-training enable |
| refclk_en_o | output | 1 | Reference clock enable |
| ep_rst_n_o | output | 1 | Endpoint reset, active low |
| pwr_on_o | output | 1 | Board power switch |
| dev_type_o | output | 4 | Static device type (4 = root port) |
| los_level_o | output | LOS_W | Static loss-of-signal level |
| clk_en_o | output | N_CLK | Clock gate enables, bit 0 first |
| link_ok_o | output | 1 | Sequence ended with link up |
| link_fail_o | output | 1 | Sequence ended after all polls failed |
| clk_err_o | output | 1 | Sequence aborted on a missing clock acknowledge |

## Verification
The path that is hardest to reach from the ports is the clock-error unwind. A gate in the middle of the chain has to stay unacknowledged while the gates below it were acknowledged. The bench builds each acknowledge from the matching enable ANDed with a per-bit mask, and clears the mask bit of gate 2. That gives a partial rise followed by a reverse unwind. The scoreboard expects every output change as a separate step, so a merged, missing or reordered step shows up as a mismatch. A second start pulse during the endpoint reset window shows that a running sequence is not disturbed.

// File: rtl/pcie_seq_pkg.sv
package pcie_seq_pkg;

    localparam logic [3:0] DEV_ROOT_PORT = 4'd4;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_EPRST,
        SQ_RSTHI,
        SQ_PHYCFG,
        SQ_PWR,
        SQ_REFCLK,
        SQ_CLKS,
        SQ_SETTLE,
        SQ_POLL,
        SQ_UP,
        SQ_FAIL,
        SQ_ERR
    } seq_state_e;

    typedef enum logic [2:0] {
        CK_IDLE,
        CK_RAISE,
        CK_UNWIND,
        CK_DONE,
        CK_ERR
    } chain_state_e;

    typedef struct packed {
        logic test_pd;
        logic train_en;
        logic refclk_en;
        logic ep_rst_n;
        logic cfg_on;
        logic link_ok;
        logic link_fail;
        logic clk_err;
    } ctrl_t;

    function automatic int unsigned width_for(int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Control levels implied by each sequencer state
    function automatic ctrl_t decode_ctrl(seq_state_e s);
        ctrl_t c;
        c = '{test_pd: 1'b1, default: 1'b0};
        unique case (s)
            SQ_IDLE:   ;
            SQ_EPRST:  c.train_en = 1'b1;
            SQ_RSTHI:  begin c.train_en = 1'b1; c.ep_rst_n = 1'b1; end
            SQ_PHYCFG,
            SQ_PWR:    begin c.ep_rst_n = 1'b1; c.cfg_on = 1'b1; end
            SQ_REFCLK,
            SQ_CLKS,
            SQ_SETTLE: begin
                c.test_pd = 1'b0; c.refclk_en = 1'b1;
                c.ep_rst_n = 1'b1; c.cfg_on = 1'b1;
            end
            SQ_POLL, SQ_UP, SQ_FAIL: begin
                c.test_pd = 1'b0; c.refclk_en = 1'b1; c.train_en = 1'b1;
                c.ep_rst_n = 1'b1; c.cfg_on = 1'b1;
                c.link_ok = (s == SQ_UP);
                c.link_fail = (s == SQ_FAIL);
            end
            SQ_ERR: begin
                c.test_pd = 1'b0; c.refclk_en = 1'b1;
                c.ep_rst_n = 1'b1; c.cfg_on = 1'b1; c.clk_err = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/clk_gate_chain.sv
module clk_gate_chain
    import pcie_seq_pkg::*;
#(
    parameter int N       = 4,
    parameter int ACK_TMO = 1000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         drop_i,
    input  logic         go_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] en_o,
    output logic         done_o,
    output logic         err_o
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int TW = width_for(ACK_TMO);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    chain_state_e st_q;
    logic [IW-1:0] idx_q;
    logic [N-1:0]  en_q;
    logic          t_load, t_zero;

    assign t_load = !drop_i &&
                    (((st_q == CK_IDLE) && go_i) ||
                     ((st_q == CK_RAISE) && ack_i[idx_q] && (idx_q != LAST)));

    seq_timer #(.W(TW)) u_ack_tmr (
        .clk       (clk),
        .rst       (rst),
        .load_i    (t_load),
        .load_val_i(TW'(ACK_TMO - 1)),
        .zero_o    (t_zero)
    );

    always_ff @(posedge clk) begin
        if (rst || drop_i) begin
            st_q  <= CK_IDLE;
            idx_q <= '0;
            en_q  <= '0;
        end else begin
            unique case (st_q)
                CK_IDLE: if (go_i) begin
                    st_q    <= CK_RAISE;
                    idx_q   <= '0;
                    en_q[0] <= 1'b1;
                end
                CK_RAISE: begin
                    if (ack_i[idx_q]) begin
                        if (idx_q == LAST) begin
                            st_q <= CK_DONE;
                        end else begin
                            idx_q <= idx_q + IW'(1);
                            en_q[idx_q + IW'(1)] <= 1'b1;
                        end
                    end else if (t_zero) begin
                        st_q <= CK_UNWIND;
                    end
                end
                CK_UNWIND: begin
                    en_q[idx_q] <= 1'b0;
                    if (idx_q == '0) st_q <= CK_ERR;
                    else             idx_q <= idx_q - IW'(1);
                end
                CK_DONE, CK_ERR: ;
                default: st_q <= CK_IDLE;
            endcase
        end
    end

    assign en_o   = en_q;
    assign done_o = (st_q == CK_DONE);
    assign err_o  = (st_q == CK_ERR);
endmodule

// File: rtl/pcie_bringup_seq.sv
module pcie_bringup_seq
    import pcie_seq_pkg::*;
#(
    parameter int N_CLK      = 4,
    parameter int RST_CYC    = 12_500_000,
    parameter int SETTLE_CYC = 25_000,
    parameter int ACK_TMO    = 1_000,
    parameter int POLL_GAP   = 62_500,
    parameter int MAX_POLL   = 200,
    parameter int LOS_W      = 5,
    parameter int LOS_LEVEL  = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             has_pwr_i,
    input  logic [N_CLK-1:0] clk_ack_i,
    input  logic             link_up_i,
    output logic             test_pd_o,
    output logic             train_en_o,
    output logic             refclk_en_o,
    output logic             ep_rst_n_o,
    output logic             pwr_on_o,
    output logic [3:0]       dev_type_o,
    output logic [LOS_W-1:0] los_level_o,
    output logic [N_CLK-1:0] clk_en_o,
    output logic             link_ok_o,
    output logic             link_fail_o,
    output logic             clk_err_o
);
    localparam int TW = width_for(max3(RST_CYC, SETTLE_CYC, POLL_GAP));
    localparam int PW = width_for(MAX_POLL);

    seq_state_e    state_q, nxt;
    logic [PW-1:0] polls_q;
    logic          pwr_q;
    logic          accept;
    logic          t_load, t_zero;
    logic [TW-1:0] t_val;
    logic          ch_done, ch_err;
    ctrl_t         ctrl;

    assign accept = start_i && (state_q inside {SQ_IDLE, SQ_UP, SQ_FAIL, SQ_ERR});

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            SQ_IDLE, SQ_UP, SQ_FAIL, SQ_ERR: if (accept) nxt = SQ_EPRST;
            SQ_EPRST:  if (t_zero) nxt = SQ_RSTHI;
            SQ_RSTHI:  nxt = SQ_PHYCFG;
            SQ_PHYCFG: nxt = SQ_PWR;
            SQ_PWR:    nxt = SQ_REFCLK;
            SQ_REFCLK: nxt = SQ_CLKS;
            SQ_CLKS: begin
                if (ch_err)       nxt = SQ_ERR;
                else if (ch_done) nxt = SQ_SETTLE;
            end
            SQ_SETTLE: if (t_zero) nxt = SQ_POLL;
            SQ_POLL: if (t_zero) begin
                if (link_up_i)                         nxt = SQ_UP;
                else if (polls_q == PW'(MAX_POLL - 1)) nxt = SQ_FAIL;
            end
            default: nxt = SQ_IDLE;
        endcase
    end

    // Timer reloads on every state change and on each poll interval
    assign t_load = (nxt != state_q) || ((state_q == SQ_POLL) && t_zero);

    always_comb begin
        unique case (nxt)
            SQ_EPRST:  t_val = TW'(RST_CYC - 1);
            SQ_SETTLE: t_val = TW'(SETTLE_CYC - 1);
            SQ_POLL:   t_val = TW'(POLL_GAP - 1);
            default:   t_val = '0;
        endcase
    end

    seq_timer #(.W(TW)) u_phase_tmr (
        .clk       (clk),
        .rst       (rst),
        .load_i    (t_load),
        .load_val_i(t_val),
        .zero_o    (t_zero)
    );

    clk_gate_chain #(.N(N_CLK), .ACK_TMO(ACK_TMO)) u_chain (
        .clk   (clk),
        .rst   (rst),
        .drop_i(accept),
        .go_i  (state_q == SQ_REFCLK),
        .ack_i (clk_ack_i),
        .en_o  (clk_en_o),
        .done_o(ch_done),
        .err_o (ch_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            polls_q <= '0;
            pwr_q   <= 1'b0;
        end else begin
            state_q <= nxt;
            if (accept) pwr_q <= has_pwr_i;
            if ((nxt == SQ_POLL) && (state_q != SQ_POLL)) polls_q <= '0;
            else if ((state_q == SQ_POLL) && t_zero)      polls_q <= polls_q + PW'(1);
        end
    end

    assign ctrl        = decode_ctrl(state_q);
    assign test_pd_o   = ctrl.test_pd;
    assign train_en_o  = ctrl.train_en;
    assign refclk_en_o = ctrl.refclk_en;
    assign ep_rst_n_o  = ctrl.ep_rst_n;
    assign link_ok_o   = ctrl.link_ok;
    assign link_fail_o = ctrl.link_fail;
    assign clk_err_o   = ctrl.clk_err;
    assign pwr_on_o    = pwr_q && !(state_q inside {SQ_IDLE, SQ_EPRST, SQ_RSTHI, SQ_PHYCFG});
    assign dev_type_o  = ctrl.cfg_on ? DEV_ROOT_PORT : 4'd0;
    assign los_level_o = ctrl.cfg_on ? LOS_W'(LOS_LEVEL) : '0;
endmodule

// File: rtl/pcie_bringup_seq_chk.sv
module pcie_bringup_seq_chk #(
    parameter int N_CLK = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             link_up_i,
    input logic             test_pd_o,
    input logic             train_en_o,
    input logic             refclk_en_o,
    input logic             ep_rst_n_o,
    input logic [3:0]       dev_type_o,
    input logic [N_CLK-1:0] clk_en_o,
    input logic             link_ok_o,
    input logic             link_fail_o,
    input logic             clk_err_o
);
    for (genvar k = 1; k < N_CLK; k++) begin : g_order
        // R5
        rise_order_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(clk_en_o[k]) |-> clk_en_o[k-1]);
        // R9
        unwind_order_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(clk_en_o[k-1]) |-> !clk_en_o[k]);
    end

    // R4
    refclk_pd_chk: assert property (@(posedge clk) disable iff (rst)
        refclk_en_o |-> !test_pd_o && dev_type_o == 4'd4);

    // R6
    train_after_clks_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(train_en_o) && ep_rst_n_o) |-> (&clk_en_o));

    // R5
    clk_needs_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (|clk_en_o) |-> refclk_en_o);

    // R7
    ok_on_link_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_ok_o) |-> $past(link_up_i));

    // R9
    err_clocks_off_chk: assert property (@(posedge clk) disable iff (rst)
        clk_err_o |-> (clk_en_o == '0) && !train_en_o);

    // R8
    one_status_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({link_ok_o, link_fail_o, clk_err_o}));
endmodule

bind pcie_bringup_seq pcie_bringup_seq_chk #(.N_CLK(N_CLK)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .link_up_i  (link_up_i),
    .test_pd_o  (test_pd_o),
    .train_en_o (train_en_o),
    .refclk_en_o(refclk_en_o),
    .ep_rst_n_o (ep_rst_n_o),
    .dev_type_o (dev_type_o),
    .clk_en_o   (clk_en_o),
    .link_ok_o  (link_ok_o),
    .link_fail_o(link_fail_o),
    .clk_err_o  (clk_err_o)
);

// File: tb/sim_pcie_bringup_seq.sv
`timescale 1ns/1ps
module sim_pcie_bringup_seq;
    localparam int N_CLK = 4, RST_CYC = 20, SETTLE_CYC = 30, ACK_TMO = 8;
    localparam int POLL_GAP = 4, MAX_POLL = 6, LOS_W = 5, LOS_LEVEL = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, has_pwr_i = 1'b0, link_up_i = 1'b0;
    logic [N_CLK-1:0] ack_mask = '1;
    logic [N_CLK-1:0] clk_ack_i, clk_en_o;
    logic test_pd_o, train_en_o, refclk_en_o, ep_rst_n_o, pwr_on_o;
    logic [3:0] dev_type_o;
    logic [LOS_W-1:0] los_level_o;
    logic link_ok_o, link_fail_o, clk_err_o;

    always #4 clk = ~clk;
    assign clk_ack_i = clk_en_o & ack_mask;

    pcie_bringup_seq #(
        .N_CLK(N_CLK), .RST_CYC(RST_CYC), .SETTLE_CYC(SETTLE_CYC), .ACK_TMO(ACK_TMO),
        .POLL_GAP(POLL_GAP), .MAX_POLL(MAX_POLL), .LOS_W(LOS_W), .LOS_LEVEL(LOS_LEVEL)
    ) u0 (.*);

    typedef struct packed {
        logic tpd, tr, rf, rn, pw, cf;
        logic [3:0] ck;
        logic ok, fl, er;
    } snap_t;

    snap_t exp_q[$];
    string tag_q[$];
    int    ev_cyc[$];
    int    cyc = 0, errors = 0, checks = 0;
    bit    mon_on = 1'b0;

    function automatic snap_t take();
        snap_t s;
        s.tpd = test_pd_o; s.tr = train_en_o; s.rf = refclk_en_o; s.rn = ep_rst_n_o;
        s.pw = pwr_on_o; s.ck = clk_en_o; s.ok = link_ok_o; s.fl = link_fail_o; s.er = clk_err_o;
        s.cf = (dev_type_o == 4'd4) && (los_level_o == LOS_W'(LOS_LEVEL));
        return s;
    endfunction

    function automatic snap_t mk(bit tpd, bit tr, bit rf, bit rn, bit pw, bit cf,
                                 logic [3:0] ck, bit ok, bit fl, bit er);
        return '{tpd, tr, rf, rn, pw, cf, ck, ok, fl, er};
    endfunction

    task automatic check(bit cond, string req, string what, int act, int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(snap_t s, string tag);
        exp_q.push_back(s);
        tag_q.push_back(tag);
    endtask

    always @(posedge clk) cyc++;

    // Monitor: every output change must match the next expected step
    initial begin
        snap_t prev, cur, e;
        string t;
        wait (mon_on);
        prev = take();
        forever begin
            @(negedge clk);
            cur = take();
            if (cur != prev) begin
                checks++;
                ev_cyc.push_back(cyc);
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R11 unexpected change: actual=%h expected=%h", cur, prev);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (cur != e) begin
                        errors++;
                        $display("FAIL %s step mismatch: actual=%h expected=%h", t, cur, e);
                    end
                end
                prev = cur;
            end
        end
    end

    task automatic drain(string req);
        for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, req, "steps left outstanding", exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset levels
        check(take() == mk(1,0,0,0,0,0,4'h0,0,0,0), "R1", "reset levels", take(), mk(1,0,0,0,0,0,4'h0,0,0,0));
        check(dev_type_o == 0 && los_level_o == 0, "R1", "static cfg idle", dev_type_o, 0);
        mon_on = 1'b1;
        @(negedge clk);

        // Normal bring-up with power switch, link comes up (R2..R7, R11)
        has_pwr_i = 1'b1; ack_mask = '1; link_up_i = 1'b0;
        b = ev_cyc.size();
        push(mk(1,1,0,0,0,0,4'h0,0,0,0), "R2");
        push(mk(1,1,0,1,0,0,4'h0,0,0,0), "R2");
        push(mk(1,0,0,1,0,1,4'h0,0,0,0), "R3");
        push(mk(1,0,0,1,1,1,4'h0,0,0,0), "R4");
        push(mk(0,0,1,1,1,1,4'h0,0,0,0), "R4");
        push(mk(0,0,1,1,1,1,4'h1,0,0,0), "R5");
        push(mk(0,0,1,1,1,1,4'h3,0,0,0), "R5");
        push(mk(0,0,1,1,1,1,4'h7,0,0,0), "R5");
        push(mk(0,0,1,1,1,1,4'hF,0,0,0), "R5");
        push(mk(0,1,1,1,1,1,4'hF,0,0,0), "R6");
        push(mk(0,1,1,1,1,1,4'hF,1,0,0), "R7");
        pulse_start();
        repeat (5) @(negedge clk);
        pulse_start();  // R11: ignored mid-sequence
        for (int i = 0; i < 500 && ev_cyc.size() < b + 10; i++) @(negedge clk);
        repeat (6) @(negedge clk);
        link_up_i = 1'b1;
        drain("R7");
        if (ev_cyc.size() >= b + 10) begin
            check(ev_cyc[b+1] - ev_cyc[b] == RST_CYC, "R2", "endpoint reset width",
                  ev_cyc[b+1] - ev_cyc[b], RST_CYC);
            check(ev_cyc[b+9] - ev_cyc[b+8] >= SETTLE_CYC && ev_cyc[b+9] - ev_cyc[b+8] <= SETTLE_CYC + 2,
                  "R6", "settle delay", ev_cyc[b+9] - ev_cyc[b+8], SETTLE_CYC);
        end
        link_up_i = 1'b0;
        repeat (3) @(negedge clk);

        // Restart without power switch, link never comes up (R10, R8)
        has_pwr_i = 1'b0;
        b = ev_cyc.size();
        push(mk(1,1,0,0,0,0,4'h0,0,0,0), "R10");
        push(mk(1,1,0,1,0,0,4'h0,0,0,0), "R2");
        push(mk(1,0,0,1,0,1,4'h0,0,0,0), "R3");
        push(mk(0,0,1,1,0,1,4'h0,0,0,0), "R4");
        push(mk(0,0,1,1,0,1,4'h1,0,0,0), "R5");
        push(mk(0,0,1,1,0,1,4'h3,0,0,0), "R5");
        push(mk(0,0,1,1,0,1,4'h7,0,0,0), "R5");
        push(mk(0,0,1,1,0,1,4'hF,0,0,0), "R5");
        push(mk(0,1,1,1,0,1,4'hF,0,0,0), "R6");
        push(mk(0,1,1,1,0,1,4'hF,0,1,0), "R8");
        pulse_start();
        drain("R8");
        if (ev_cyc.size() >= b + 10)
            check(ev_cyc[b+9] - ev_cyc[b+8] == MAX_POLL * POLL_GAP, "R8", "fail time",
                  ev_cyc[b+9] - ev_cyc[b+8], MAX_POLL * POLL_GAP);
        check(dev_type_o == 4 && los_level_o == LOS_W'(LOS_LEVEL), "R3", "static cfg values",
              los_level_o, LOS_LEVEL);

        // Restart with gate 2 never acknowledged (R9, R10)
        has_pwr_i = 1'b1; ack_mask = 4'b1011;
        push(mk(1,1,0,0,0,0,4'h0,0,0,0), "R10");
        push(mk(1,1,0,1,0,0,4'h0,0,0,0), "R2");
        push(mk(1,0,0,1,0,1,4'h0,0,0,0), "R3");
        push(mk(1,0,0,1,1,1,4'h0,0,0,0), "R4");
        push(mk(0,0,1,1,1,1,4'h0,0,0,0), "R4");
        push(mk(0,0,1,1,1,1,4'h1,0,0,0), "R5");
        push(mk(0,0,1,1,1,1,4'h3,0,0,0), "R5");
        push(mk(0,0,1,1,1,1,4'h7,0,0,0), "R5");
        push(mk(0,0,1,1,1,1,4'h3,0,0,0), "R9");
        push(mk(0,0,1,1,1,1,4'h1,0,0,0), "R9");
        push(mk(0,0,1,1,1,1,4'h0,0,0,0), "R9");
        push(mk(0,0,1,1,1,1,4'h0,0,0,1), "R9");
        pulse_start();
        drain("R9");
        repeat (50) @(negedge clk);
        check(train_en_o == 0 && clk_err_o == 1, "R9", "held after error", train_en_o, 0);
        finish_run();
    end
endmodule